// File: doc/BRIEF.md
# Microstep Translator Sequencer

The block turns a step-and-direction pulse interface into current setpoints for the two windings of a bipolar stepper motor. It keeps an electrical position of 64 steps per electrical cycle. Each rising edge on the step input moves that position by a stride that the resolution select chooses, and the direction input sets which way it moves. For each winding it reports an 8-bit magnitude code, a polarity bit and a decay-mode bit. A downstream DAC and chopper use these outputs to drive the bridges.

Winding 1 follows a cosine profile over the 64 positions and winding 2 follows a sine profile. Both magnitudes come from one quarter-wave table with 17 entries. The decay mode of each winding is chosen at every step. If the winding's magnitude falls, it gets mixed decay. If the magnitude rises or stays the same, it gets slow decay. A synchronous active-low home input and the asynchronous power-on reset both return the sequencer to the 45-degree home position.

Top module: `mstep_translator`

## Requirements
- R1: After power-on reset (rst_ni low), both windings report magnitude 180, positive polarity (neg bit 0) and mixed decay (mixed bit 1).
- R2: The resolution select {ms2_i, ms1_i} sets the stride in positions out of 64: 00 gives 16 (full), 01 gives 8 (half), 10 gives 4 (quarter), 11 gives 1 (sixteenth).
- R3: At each step, dir_i high adds the stride to the position and dir_i low subtracts it.
- R4: The position wraps modulo 64 in both directions.
- R5: dir_i, ms1_i and ms2_i take effect only at a synchronized step rising edge. With no step edge, the outputs hold.
- R6: While home_ni is low, the position is held at home (45 degrees), both windings report mixed decay, and step edges are ignored. A step level that is still high when home_ni is released causes no advance.
- R7: At each step, a winding whose new magnitude is lower than its previous magnitude reports mixed (1). Otherwise it reports slow (0).
- R8: At position k, winding 1 reports |cos(k*5.625 deg)| and winding 2 reports |sin(k*5.625 deg)|, each as round(percent*2.55). The quarter-wave codes are 255,254,250,244,236,225,212,197,180,162,142,120,98,74,50,25,0. The neg bit is 1 when the signed value is below zero.
- R9: A winding at magnitude 0 reports positive polarity (neg 0).
- R10: A step pulse advances the position exactly once, however long it is held. The outputs change on the third rising clock edge after step_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| home_ni | input | 1 | Synchronous active-low return-to-home and step inhibit |
| step_i | input | 1 | Asynchronous step pulse; rising edge advances |
| dir_i | input | 1 | Direction: 1 forward, 0 backward |
| ms1_i | input | 1 | Resolution select, low bit |
| ms2_i | input | 1 | Resolution select, high bit |
| ph1_mag_o | output | 8 | Winding 1 magnitude code (255 = 100%) |
| ph1_neg_o | output | 1 | Winding 1 polarity, 1 = negative |
| ph1_mixed_o | output | 1 | Winding 1 decay, 1 = mixed, 0 = slow |
| ph2_mag_o | output | 8 | Winding 2 magnitude code |
| ph2_neg_o | output | 1 | Winding 2 polarity, 1 = negative |
| ph2_mixed_o | output | 1 | Winding 2 decay, 1 = mixed, 0 = slow |

## Verification
Some properties are checked on every cycle:
- The synchronized edge never lasts two cycles.
- The position holds between edges and moves only by one of the legal strides.
- Home forces the home position and mixed decay.
- Each decay bit agrees with the change in its winding's reported magnitude.
- A zero magnitude is never flagged negative.

The exact magnitude codes and signs at each position, the mapping from select code to stride, the wrap in both directions and the three-edge latency can only be shown by the bench's step sequences. The same holds for select and direction changes between edges being ignored and for a step level that is still high when home is released.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  localparam int IDX_W    = 6;
  localparam int POSITIONS = 1 << IDX_W;
  localparam int QTR      = POSITIONS / 4;
  localparam int MAG_W    = 8;
  localparam int NPH      = 2;
  localparam int HOME_POS = QTR / 2;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [MAG_W-1:0] mag_t;

  // encoding is {ms2, ms1}
  typedef enum logic [1:0] {
    RES_FULL = 2'b00,
    RES_HALF = 2'b01,
    RES_QTR  = 2'b10,
    RES_SIXT = 2'b11
  } res_e;

  function automatic idx_t res_stride(input res_e r);
    case (r)
      RES_FULL: return idx_t'(QTR);
      RES_HALF: return idx_t'(QTR / 2);
      RES_QTR:  return idx_t'(QTR / 4);
      default:  return idx_t'(1);
    endcase
  endfunction

  // |cos| over one quadrant, 255 = full scale
  function automatic mag_t quad_mag(input logic [4:0] j);
    case (j)
      5'd0:  return 8'd255;
      5'd1:  return 8'd254;
      5'd2:  return 8'd250;
      5'd3:  return 8'd244;
      5'd4:  return 8'd236;
      5'd5:  return 8'd225;
      5'd6:  return 8'd212;
      5'd7:  return 8'd197;
      5'd8:  return 8'd180;
      5'd9:  return 8'd162;
      5'd10: return 8'd142;
      5'd11: return 8'd120;
      5'd12: return 8'd98;
      5'd13: return 8'd74;
      5'd14: return 8'd50;
      5'd15: return 8'd25;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/mstep_edge_sync.sv
module mstep_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], d_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mstep_index.sv
module mstep_index
  import mstep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic home_ni,
  input  logic adv_i,
  input  logic dir_i,
  input  res_e res_i,
  output idx_t idx_o,
  output idx_t idx_nxt_o
);
  idx_t idx_q, stride;

  assign stride = res_stride(res_i);

  always_comb begin
    if (!home_ni)   idx_nxt_o = idx_t'(HOME_POS);
    else if (adv_i) idx_nxt_o = dir_i ? idx_q + stride : idx_q - stride;
    else            idx_nxt_o = idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= idx_t'(HOME_POS);
    else         idx_q <= idx_nxt_o;
  end

  assign idx_o = idx_q;

  assert_home_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !home_ni |=> idx_q == idx_t'(HOME_POS));
  assert_hold_no_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && home_ni) |=> $stable(idx_q));
  assert_legal_stride_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && home_ni) |=> ((idx_q - $past(idx_q)) inside
      {6'd1, 6'd4, 6'd8, 6'd16, 6'd48, 6'd56, 6'd60, 6'd63}));
endmodule

// File: rtl/mstep_phase_lut.sv
module mstep_phase_lut
  import mstep_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  idx_t idx_i,
  output mag_t mag_o,
  output logic neg_o
);
  idx_t       k;
  logic [4:0] m;
  logic [5:0] mirror;

  assign k      = idx_i - idx_t'(OFFSET);
  assign m      = k[4:0];
  assign mirror = 6'd32 - {1'b0, m};

  always_comb begin
    if (m <= 5'd16) mag_o = quad_mag(m);
    else            mag_o = quad_mag(mirror[4:0]);
  end

  // cosine negative strictly between the two zero crossings
  assign neg_o = (k > idx_t'(QTR)) && (k < idx_t'(3 * QTR));
endmodule

// File: rtl/mstep_decay.sv
module mstep_decay
  import mstep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic home_ni,
  input  logic adv_i,
  input  mag_t cur_mag_i,
  input  mag_t nxt_mag_i,
  output logic mixed_o
);
  logic mixed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mixed_q <= 1'b1;
    else if (!home_ni) mixed_q <= 1'b1;
    else if (adv_i)    mixed_q <= nxt_mag_i < cur_mag_i;
  end

  assign mixed_o = mixed_q;

  assert_home_mixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !home_ni |=> mixed_q);
endmodule

// File: rtl/mstep_translator.sv
module mstep_translator
  import mstep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       home_ni,
  input  logic       step_i,
  input  logic       dir_i,
  input  logic       ms1_i,
  input  logic       ms2_i,
  output logic [7:0] ph1_mag_o,
  output logic       ph1_neg_o,
  output logic       ph1_mixed_o,
  output logic [7:0] ph2_mag_o,
  output logic       ph2_neg_o,
  output logic       ph2_mixed_o
);
  logic step_rise;
  idx_t idx, idx_nxt;
  mag_t mag_cur [NPH];
  mag_t mag_nxt [NPH];
  logic neg_cur [NPH];
  logic neg_nxt [NPH];
  logic mixed   [NPH];

  mstep_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (step_i),
    .rise_o(step_rise)
  );

  mstep_index u_index (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .home_ni  (home_ni),
    .adv_i    (step_rise),
    .dir_i    (dir_i),
    .res_i    (res_e'({ms2_i, ms1_i})),
    .idx_o    (idx),
    .idx_nxt_o(idx_nxt)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    // winding 1 is cosine; winding 2 lags by a quarter cycle (sine)
    mstep_phase_lut #(.OFFSET(p * QTR)) u_lut_cur (
      .idx_i(idx),
      .mag_o(mag_cur[p]),
      .neg_o(neg_cur[p])
    );
    mstep_phase_lut #(.OFFSET(p * QTR)) u_lut_nxt (
      .idx_i(idx_nxt),
      .mag_o(mag_nxt[p]),
      .neg_o(neg_nxt[p])
    );
    mstep_decay u_decay (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .home_ni  (home_ni),
      .adv_i    (step_rise),
      .cur_mag_i(mag_cur[p]),
      .nxt_mag_i(mag_nxt[p]),
      .mixed_o  (mixed[p])
    );

    assert_decay_follows_mag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_rise && home_ni) |=> mixed[p] == (mag_cur[p] < $past(mag_cur[p])));
    assert_zero_positive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_cur[p] |-> mag_cur[p] != '0);
  end

  assign ph1_mag_o   = mag_cur[0];
  assign ph1_neg_o   = neg_cur[0];
  assign ph1_mixed_o = mixed[0];
  assign ph2_mag_o   = mag_cur[1];
  assign ph2_neg_o   = neg_cur[1];
  assign ph2_mixed_o = mixed[1];

  // next-state polarity only matters to the lookahead magnitude path
  logic unused_neg_nxt;
  assign unused_neg_nxt = neg_nxt[0] ^ neg_nxt[1];
endmodule

// File: tb/mstep_translator_test.sv
module mstep_translator_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, home_n = 1'b1, step = 1'b0, dir = 1'b1, ms1 = 1'b0, ms2 = 1'b0;
  logic [7:0] m1, m2;
  logic n1, x1, n2, x2;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mstep_translator uut (
    .clk_i(clk), .rst_ni(rst_n), .home_ni(home_n), .step_i(step),
    .dir_i(dir), .ms1_i(ms1), .ms2_i(ms2),
    .ph1_mag_o(m1), .ph1_neg_o(n1), .ph1_mixed_o(x1),
    .ph2_mag_o(m2), .ph2_neg_o(n2), .ph2_mixed_o(x2)
  );

  typedef struct packed {
    logic       dir;
    logic       ms2;
    logic       ms1;
    logic [7:0] m1;
    logic       n1;
    logic       x1;
    logic [7:0] m2;
    logic       n2;
    logic       x2;
  } vec_t;

  // walk from home; expected position after each step noted
  localparam vec_t VECS [17] = '{
    '{1'b1, 1'b1, 1'b1, 8'd162, 1'b0, 1'b1, 8'd197, 1'b0, 1'b0}, // 9
    '{1'b1, 1'b0, 1'b1, 8'd25,  1'b1, 1'b1, 8'd254, 1'b0, 1'b0}, // 17
    '{1'b1, 1'b1, 1'b0, 8'd120, 1'b1, 1'b0, 8'd225, 1'b0, 1'b1}, // 21
    '{1'b1, 1'b0, 1'b0, 8'd225, 1'b1, 1'b0, 8'd120, 1'b1, 1'b1}, // 37
    '{1'b0, 1'b1, 1'b1, 8'd236, 1'b1, 1'b0, 8'd98,  1'b1, 1'b1}, // 36
    '{1'b0, 1'b0, 1'b0, 8'd98,  1'b1, 1'b1, 8'd236, 1'b0, 1'b0}, // 20
    '{1'b0, 1'b0, 1'b1, 8'd98,  1'b0, 1'b0, 8'd236, 1'b0, 1'b0}, // 12 equal mags
    '{1'b0, 1'b1, 1'b0, 8'd180, 1'b0, 1'b0, 8'd180, 1'b0, 1'b1}, // 8
    '{1'b0, 1'b0, 1'b0, 8'd180, 1'b0, 1'b0, 8'd180, 1'b1, 1'b0}, // 56 wrap down
    '{1'b1, 1'b0, 1'b0, 8'd180, 1'b0, 1'b0, 8'd180, 1'b0, 1'b0}, // 8 wrap up
    '{1'b1, 1'b1, 1'b0, 8'd98,  1'b0, 1'b1, 8'd236, 1'b0, 1'b0}, // 12
    '{1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 1'b1, 8'd255, 1'b0, 1'b0}, // 16
    '{1'b1, 1'b1, 1'b1, 8'd25,  1'b1, 1'b0, 8'd254, 1'b0, 1'b1}, // 17
    '{1'b0, 1'b1, 1'b1, 8'd0,   1'b0, 1'b1, 8'd255, 1'b0, 1'b0}, // 16
    '{1'b1, 1'b0, 1'b0, 8'd255, 1'b1, 1'b0, 8'd0,   1'b0, 1'b1}, // 32
    '{1'b1, 1'b0, 1'b0, 8'd0,   1'b0, 1'b1, 8'd255, 1'b1, 1'b0}, // 48
    '{1'b0, 1'b1, 1'b1, 8'd25,  1'b1, 1'b0, 8'd254, 1'b1, 1'b1}  // 47
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int em1, input int en1, input int ex1,
                         input int em2, input int en2, input int ex2);
    chk({tag, " ph1 mag R8"}, int'(m1), em1);
    chk({tag, " ph1 sign R8"}, int'(n1), en1);
    chk({tag, " ph1 decay R7"}, int'(x1), ex1);
    chk({tag, " ph2 mag R8"}, int'(m2), em2);
    chk({tag, " ph2 sign R8"}, int'(n2), en2);
    chk({tag, " ph2 decay R7"}, int'(x2), ex2);
  endtask

  task automatic pulse(input logic d, input logic s2, input logic s1);
    dir = d; ms2 = s2; ms1 = s1;
    @(negedge clk);
    step = 1'b1;
    repeat (4) @(negedge clk);
    step = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 180, 0, 1, 180, 0, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 after release", 180, 0, 1, 180, 0, 1);

    for (int i = 0; i < 17; i++) begin
      pulse(VECS[i].dir, VECS[i].ms2, VECS[i].ms1);
      chk_all((i == 8 || i == 9) ? $sformatf("R4 wrap vec%0d", i)
                                 : $sformatf("R2/R3 vec%0d", i),
              int'(VECS[i].m1), int'(VECS[i].n1), int'(VECS[i].x1),
              int'(VECS[i].m2), int'(VECS[i].n2), int'(VECS[i].x2));
    end

    // R5: select and direction changes without a step do nothing
    dir = 1'b0; ms2 = 1'b0; ms1 = 1'b0;
    repeat (10) @(negedge clk);
    chk_all("R5 no edge", 25, 1, 0, 254, 1, 1);

    // R10 latency and single advance; R5 changes after the edge ignored
    dir = 1'b1; ms2 = 1'b1; ms1 = 1'b1;
    @(negedge clk);
    step = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 before third edge", int'(m1), 25);
    @(negedge clk);
    chk("R10 at third edge", int'(m1), 0);
    dir = 1'b0; ms2 = 1'b0; ms1 = 1'b0;
    repeat (20) @(negedge clk);
    step = 1'b0;
    repeat (4) @(negedge clk);
    chk_all("R10 long pulse R9", 0, 0, 1, 255, 1, 0);

    pulse(1'b0, 1'b0, 1'b0);
    chk_all("R5 new select used", 255, 1, 0, 0, 0, 1);

    // R6: home input
    home_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R6 home", 180, 0, 1, 180, 0, 1);
    pulse(1'b1, 1'b1, 1'b1);
    chk_all("R6 step ignored", 180, 0, 1, 180, 0, 1);
    step = 1'b1;
    repeat (6) @(negedge clk);
    home_n = 1'b1;
    repeat (6) @(negedge clk);
    step = 1'b0;
    repeat (4) @(negedge clk);
    chk_all("R6 held level", 180, 0, 1, 180, 0, 1);
    pulse(1'b1, 1'b1, 1'b1);
    chk_all("R6 resume", 162, 0, 1, 197, 0, 0);

    // R1: power-on reset mid-run
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 mid-run reset", 180, 0, 1, 180, 0, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule